// File: doc/BRIEF.md
# Pipelined Priority Bus Arbiter

This block decides which of several bus masters may drive a shared system bus whose address phase and data phase are separate tenures. Every master raises a request together with a 2-bit priority. The arbiter hands out the address bus as a one-hot grant. Address tenures may run ahead of data tenures, up to a depth that software selects. Each finished address tenure enqueues the master's index, and the data bus is then granted strictly in that order. A slave strobe marks the end of each address tenure and of each data tenure.

Two further policies shape the address side. In the first, a winning master may keep the bus for a programmed run of back-to-back transactions, each one a 32-byte line. A strictly more urgent request ends that run at the next tenure boundary. In the second, while nobody requests, the address grant can be dropped, left on the master that used the bus last, or parked on a master chosen by configuration. A parked master starts its address phase without waiting for arbitration.

Top module: `pbus_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, both `addr_gnt` and `data_gnt` are all zero when parking is off.
- R2: A new address grant goes to a requester with the numerically largest priority, where master i's priority is `prio[2i+1:2i]` and 3 is the most urgent.
- R3: Among requesters that share the largest priority, the grant goes to the first one after the master that last completed an address tenure, counting upward with wrap-around. After reset that master is index 0.
- R4: The number of completed address tenures whose data tenure is still open never exceeds `cfg_depth_m1`+1 (values 0..3 mean depth 1..4). While that limit is reached, `addr_gnt` is zero. Each `data_done` frees one slot.
- R5: `data_gnt` is one-hot on the master of the oldest open tenure, or zero when none is open. The data grants follow the address tenures in their completion order. A `data_done` while `data_gnt` is set retires that tenure.
- R6: A master that completes an address tenure and still requests keeps the grant for `cfg_rep_m1`+1 consecutive tenures (values 0..7 mean 1..8). It does so only while no requester has a strictly larger priority. After that run it takes its turn under R3.
- R7: A requester with a strictly larger priority than the current owner takes the address grant at the owner's next tenure boundary, whatever is left of the owner's run.
- R8: With no requests pending, `cfg_park` selects what the idle address bus does. 00 and 11 drop the grant. 01 leaves it on the master that last completed an address tenure. 10 places it on `cfg_park_id`.
- R9: A parked master that raises its request together with `addr_done` completes its address tenure in that same cycle. A different master's request moves the grant one cycle later.
- R10: While the owner keeps its request high and `addr_done` is low, `addr_gnt` does not change.
- R11: `addr_gnt` is one-hot or zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Per-master bus request |
| prio | input | N_MST*PRIO_W | Packed per-master priorities, master i in bits [PRIO_W*i +: PRIO_W] |
| cfg_depth_m1 | input | clog2(MAX_DEPTH) | Pipeline depth minus one |
| cfg_rep_m1 | input | clog2(REP_MAX) | Consecutive tenures per grant, minus one |
| cfg_park | input | 2 | Idle parking policy |
| cfg_park_id | input | clog2(N_MST) | Master to park on in fixed-park policy |
| addr_done | input | 1 | Slave strobe: the granted address tenure ends this cycle |
| data_done | input | 1 | Slave strobe: the granted data tenure ends this cycle |
| addr_gnt | output | N_MST | One-hot address bus grant |
| data_gnt | output | N_MST | One-hot data bus grant |

## Verification
The depth sweep runs one master with `addr_done` held high and no data completions, for every depth from 1 to 4. The number of address phases it gets through separates a correct limit from an off-by-one, and a single data completion must then free exactly one more phase. The run-length sweep covers every value from 1 to 8 with two equal-priority masters. The pattern of grant switches separates a correct repeat count from a round-robin that ignores the count. Mixed-priority and late-arriving urgent requests separate starvation by priority from preemption timing. The parking patterns compare the cycle in which a parked master's phase is accepted against the cycle in which another master's phase is accepted, which separates a zero-latency park from a one-cycle move. An interleaved two-master stall, drained afterwards, shows that data grants follow address order.

// File: rtl/pbarb_pkg.sv
package pbarb_pkg;
   typedef enum logic [1:0] {
      PARK_NONE  = 2'b00,
      PARK_LAST  = 2'b01,
      PARK_FIXED = 2'b10,
      PARK_NONE2 = 2'b11
   } park_mode_e;
endpackage

// File: rtl/pbarb_pick.sv
module pbarb_pick #(
   parameter int N_MST  = 4,
   parameter int PRIO_W = 2,
   parameter int ID_W   = 2
) (
   input  logic [N_MST-1:0]        req,
   input  logic [N_MST*PRIO_W-1:0] prio,
   input  logic [ID_W-1:0]         last_id,
   output logic [ID_W-1:0]         win_id,
   output logic [PRIO_W-1:0]       top_prio
);
   logic found;

   always_comb begin
      top_prio = '0;
      for (int i = 0; i < N_MST; i++) begin
         if (req[i] && (prio[i*PRIO_W +: PRIO_W] > top_prio))
            top_prio = prio[i*PRIO_W +: PRIO_W];
      end
      win_id = last_id;
      found  = 1'b0;
      for (int k = 1; k <= N_MST; k++) begin
         int j;
         j = (int'(last_id) + k) % N_MST;
         if (!found && req[j] && (prio[j*PRIO_W +: PRIO_W] == top_prio)) begin
            win_id = ID_W'(j);
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbarb_idq.sv
module pbarb_idq #(
   parameter int DEPTH = 4,
   parameter int ID_W  = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ID_W-1:0]  push_id,
   input  logic             pop,
   output logic [ID_W-1:0]  head_id,
   output logic             head_vld,
   output logic [CNT_W-1:0] cnt
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [ID_W-1:0]  slot [DEPTH];
   logic [PTR_W-1:0] wp, rp;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= push_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= bump(wp);
         if (pop)  rp <= bump(rp);
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head_id  = slot[rp];
   assign head_vld = (cnt != '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (cnt < CNT_W'(DEPTH))); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_vld); // R5
endmodule

// File: rtl/pbus_arbiter.sv
module pbus_arbiter
   import pbarb_pkg::*;
#(
   parameter int N_MST     = 4,
   parameter int PRIO_W    = 2,
   parameter int MAX_DEPTH = 4,
   parameter int REP_MAX   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_MST-1:0]             req,
   input  logic [N_MST*PRIO_W-1:0]      prio,
   input  logic [$clog2(MAX_DEPTH)-1:0] cfg_depth_m1,
   input  logic [$clog2(REP_MAX)-1:0]   cfg_rep_m1,
   input  logic [1:0]                   cfg_park,
   input  logic [$clog2(N_MST)-1:0]     cfg_park_id,
   input  logic                         addr_done,
   input  logic                         data_done,
   output logic [N_MST-1:0]             addr_gnt,
   output logic [N_MST-1:0]             data_gnt
);
   localparam int ID_W  = $clog2(N_MST);
   localparam int CNT_W = $clog2(MAX_DEPTH + 1);
   localparam int REP_W = $clog2(REP_MAX);

   if (N_MST < 2)     begin : g_chk_mst   $error("N_MST must be at least 2");     end
   if (MAX_DEPTH < 2) begin : g_chk_depth $error("MAX_DEPTH must be at least 2"); end
   if (REP_MAX < 2)   begin : g_chk_rep   $error("REP_MAX must be at least 2");   end
   if (PRIO_W < 1)    begin : g_chk_prio  $error("PRIO_W must be positive");      end

   logic [ID_W-1:0]   own_id, own_id_n, last_id, last_n;
   logic              own_vld, own_vld_n;
   logic [REP_W-1:0]  rep_cnt, rep_n;
   logic [ID_W-1:0]   win_id, head_id;
   logic [PRIO_W-1:0] top_prio, own_prio;
   logic              head_vld, push, pop, busy, cap_ok, hi_req, keep;
   logic [CNT_W-1:0]  cnt, cnt_nxt, depth;
   park_mode_e        pmode;

   assign push     = own_vld && addr_done;
   assign pop      = data_done && head_vld;
   assign last_n   = push ? own_id : last_id;
   assign depth    = CNT_W'(cfg_depth_m1) + CNT_W'(1);
   assign cnt_nxt  = cnt + CNT_W'(push) - CNT_W'(pop);
   assign cap_ok   = cnt_nxt < depth;
   assign own_prio = prio[own_id*PRIO_W +: PRIO_W];
   assign hi_req   = (|req) && (top_prio > own_prio);
   assign busy     = own_vld && req[own_id] && !addr_done;
   assign keep     = push && req[own_id] && (rep_cnt < cfg_rep_m1) && !hi_req;
   assign pmode    = park_mode_e'(cfg_park);

   pbarb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_pick (
      .req(req), .prio(prio), .last_id(last_n),
      .win_id(win_id), .top_prio(top_prio)
   );

   pbarb_idq #(.DEPTH(MAX_DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) i_idq (
      .clk(clk), .rst_n(rst_n), .push(push), .push_id(own_id), .pop(pop),
      .head_id(head_id), .head_vld(head_vld), .cnt(cnt)
   );

   always_comb begin
      own_id_n  = own_id;
      own_vld_n = own_vld;
      rep_n     = rep_cnt;
      if (!busy) begin
         if (!cap_ok) begin
            own_vld_n = 1'b0;
            rep_n     = '0;
         end else if (|req) begin
            if (keep) begin
               rep_n = rep_cnt + REP_W'(1);
            end else begin
               own_id_n  = win_id;
               own_vld_n = 1'b1;
               rep_n     = '0;
            end
         end else begin
            rep_n = '0;
            unique case (pmode)
               PARK_LAST: begin
                  own_id_n  = last_n;
                  own_vld_n = 1'b1;
               end
               PARK_FIXED: begin
                  own_id_n  = cfg_park_id;
                  own_vld_n = 1'b1;
               end
               default: own_vld_n = 1'b0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_id  <= '0;
         own_vld <= 1'b0;
         last_id <= '0;
         rep_cnt <= '0;
      end else begin
         own_id  <= own_id_n;
         own_vld <= own_vld_n;
         last_id <= last_n;
         rep_cnt <= rep_n;
      end
   end

   for (genvar g = 0; g < N_MST; g++) begin : g_gnt
      assign addr_gnt[g] = own_vld && (own_id == ID_W'(g));
      assign data_gnt[g] = head_vld && (head_id == ID_W'(g));
   end

   AST_ADDR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_gnt)); // R11
   AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_gnt)); // R5
   AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (|addr_gnt) |-> (cnt < depth)); // R4
   AST_HOLD_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(addr_gnt & req)) && !addr_done) |=> (addr_gnt == $past(addr_gnt))); // R10
   AST_PUSH_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ((|addr_gnt) && addr_done) |=> (|data_gnt)); // R5
endmodule

// File: tb/test_pbus_arbiter.sv
`timescale 1ns/1ps
module test_pbus_arbiter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] req;
   logic [7:0] prio;
   logic [1:0] cfg_depth_m1;
   logic [2:0] cfg_rep_m1;
   logic [1:0] cfg_park;
   logic [1:0] cfg_park_id;
   logic       addr_done, data_done;
   logic [3:0] addr_gnt, data_gnt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pbus_arbiter i_pbus_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
      .cfg_depth_m1(cfg_depth_m1), .cfg_rep_m1(cfg_rep_m1),
      .cfg_park(cfg_park), .cfg_park_id(cfg_park_id),
      .addr_done(addr_done), .data_done(data_done),
      .addr_gnt(addr_gnt), .data_gnt(data_gnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic nclk();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; addr_done = 1'b0; data_done = 1'b0;
      nclk(); nclk();
      chk("R1", addr_gnt, 0);
      chk("R1", data_gnt, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0; req = '0; prio = '0; addr_done = 1'b0; data_done = 1'b0;
      cfg_depth_m1 = '0; cfg_rep_m1 = '0; cfg_park = '0; cfg_park_id = '0;

      // R4 R5: depth sweep, one master, no data completion
      for (int d = 1; d <= 4; d++) begin
         cfg_depth_m1 = 2'(d - 1); cfg_rep_m1 = '0; cfg_park = 2'b00;
         prio = 8'h01;
         do_reset();
         nclk();
         chk("R1", addr_gnt, 0);
         req = 4'b0001; addr_done = 1'b1;
         n = 0;
         repeat (12) begin nclk(); if (addr_gnt[0]) n++; end
         chk("R4", n, d);
         chk("R5", data_gnt, 4'b0001);
         data_done = 1'b1;
         n = 0;
         repeat (8) begin nclk(); data_done = 1'b0; if (addr_gnt[0]) n++; end
         chk("R4", n, 1);
      end

      // R10: grant held while addr_done low
      cfg_depth_m1 = 2'd3; prio = 8'h00;
      do_reset();
      req = 4'b0001; addr_done = 1'b0;
      repeat (3) begin nclk(); chk("R10", addr_gnt, 4'b0001); end
      chk("R10", data_gnt, 0);

      // R6 R3: run length sweep with two equal-priority masters
      for (int r = 1; r <= 8; r++) begin
         cfg_depth_m1 = 2'd3; cfg_rep_m1 = 3'(r - 1); cfg_park = 2'b00;
         prio = 8'h0A;
         do_reset();
         req = 4'b0011; addr_done = 1'b1; data_done = 1'b1;
         for (int k = 0; k < 16; k++) begin
            nclk();
            chk("R6", addr_gnt, (((k / r) % 2) == 0) ? 4'b0010 : 4'b0001);
         end
      end

      // R2 R3: mixed priorities, top level shared by masters 2 and 3
      cfg_rep_m1 = '0;
      prio = 8'hF1;
      do_reset();
      req = 4'b1101; addr_done = 1'b1; data_done = 1'b1;
      for (int k = 0; k < 8; k++) begin
         nclk();
         chk("R2", addr_gnt, (k % 2 == 0) ? 4'b0100 : 4'b1000);
      end

      // R7: urgent request cuts a long run
      cfg_rep_m1 = 3'd7;
      prio = 8'h08;
      do_reset();
      req = 4'b0001; addr_done = 1'b1; data_done = 1'b1;
      nclk(); chk("R6", addr_gnt, 4'b0001);
      nclk(); chk("R6", addr_gnt, 4'b0001);
      req = 4'b0011;
      nclk(); chk("R7", addr_gnt, 4'b0010);
      nclk(); chk("R7", addr_gnt, 4'b0010);

      // R8: parking off, codes 00 and 11
      cfg_rep_m1 = '0; prio = 8'h00;
      for (int pm = 0; pm < 4; pm += 3) begin
         cfg_park = 2'(pm);
         do_reset();
         req = 4'b0001; addr_done = 1'b1; data_done = 1'b1;
         nclk(); chk("R8", addr_gnt, 4'b0001);
         req = 4'b0000;
         nclk(); addr_done = 1'b0;
         chk("R8", addr_gnt, 0);
         nclk(); chk("R8", addr_gnt, 0);
      end

      // R8 R9: park on last owner, zero-latency restart
      cfg_park = 2'b01;
      do_reset();
      req = 4'b0100; addr_done = 1'b1; data_done = 1'b1;
      nclk(); chk("R3", addr_gnt, 4'b0100);
      req = 4'b0000;
      nclk(); addr_done = 1'b0;
      chk("R8", addr_gnt, 4'b0100);
      repeat (3) nclk();
      chk("R8", addr_gnt, 4'b0100);
      chk("R5", data_gnt, 0);
      req = 4'b0100; addr_done = 1'b1;
      nclk();
      chk("R9", data_gnt, 4'b0100);
      req = 4'b0000; addr_done = 1'b0;

      // R8 R9: park on fixed master, one-cycle move to another
      cfg_park = 2'b10; cfg_park_id = 2'd3;
      do_reset();
      nclk(); nclk();
      chk("R8", addr_gnt, 4'b1000);
      req = 4'b0010;
      nclk(); chk("R9", addr_gnt, 4'b0010);
      req = 4'b0000;
      nclk(); chk("R8", addr_gnt, 4'b1000);

      // R3 R4 R5: interleaved masters stall at depth 3, then drain in order
      cfg_park = 2'b00; cfg_depth_m1 = 2'd2; prio = 8'h00;
      do_reset();
      req = 4'b1010; addr_done = 1'b1; data_done = 1'b0;
      nclk(); chk("R3", addr_gnt, 4'b0010);
      nclk(); chk("R3", addr_gnt, 4'b1000);
      nclk(); chk("R3", addr_gnt, 4'b0010);
      nclk(); chk("R4", addr_gnt, 0);
      req = 4'b0000; addr_done = 1'b0;
      chk("R5", data_gnt, 4'b0010);
      data_done = 1'b1;
      nclk(); chk("R5", data_gnt, 4'b1000);
      nclk(); chk("R5", data_gnt, 4'b0010);
      nclk(); chk("R5", data_gnt, 0);
      data_done = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule